// File: doc/BRIEF.md
# External Bus Mode Configuration Controller

This block fixes the external address bus arrangement of a microcontroller. A three-bit operating mode, taken from pins while reset is held, chooses between a 1-Mbyte space (twenty address lines) and a 16-Mbyte space (twenty-four lines). It also chooses whether the per-area width register starts with every area at 8 bits or every area at 16 bits, and whether the low twenty address pins drive at once or wait for their direction bits.

After reset, software shapes the bus through a small write port. The area width register holds one bit per area, and the effective bus width is 16 bits as soon as any area asks for 16-bit access. The three highest bits of the bus-release register gate the top three address lines in the large-space modes. Three direction registers enable individual low address pins in the modes that start with those pins as inputs. Every output is registered, and the outputs are meant to drive the pin multiplexers and the bus sizing logic.

Top module: `xbus_cfg`

## Requirements
- R1: Modes 1, 2 and 5 give a 20-line space: `space_16m` is 0 and `addr_oe[23:20]` is 0 whatever the registers hold. Modes 3, 4 and 6 give a 24-line space with `space_16m` at 1.
- R2: In modes 1, 3, 5 and 6 the area width register (write address 0) resets to 0x00, so `bus_wide` is 0 after reset.
- R3: In modes 2 and 4 the area width register resets to 0xFF, so `bus_wide` is 1 after reset.
- R4: `bus_wide` is 1 when any bit of the area width register is 1 (1 selects 16-bit access for that area) and 0 only when all eight bits are 0.
- R5: The bus-release register (write address 1) resets to 0xFE. In 24-line modes, `addr_oe[21]`, `addr_oe[22]` and `addr_oe[23]` are 1 only while bits 5, 6 and 7 of that register are 0.
- R6: In 24-line modes `addr_oe[20]` is 1 whatever the bus-release register holds.
- R7: In modes 5 and 6, `addr_oe[19:0]` follows the direction registers, which reset to 0: address 2 bits 7..0 drive A7..A0, address 3 bits 7..0 drive A15..A8, address 4 bits 3..0 drive A19..A16, and the upper bits written to address 4 are dropped.
- R8: In modes 1 to 4, `addr_oe[19:0]` is all ones after reset, and writes to the direction registers do not change it.
- R9: The mode is captured from `mode_pins` on the clock edges that have `rst` high. Changes to the pins after reset have no effect. Codes 0 and 7 behave as mode 1.
- R10: While `rst` is high all outputs are 0. A register write sampled on one clock edge shows on the outputs after the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; mode is sampled while high |
| mode_pins | input | 3 | Operating mode code, 1 to 6 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 area width, 1 bus release, 2 to 4 direction |
| wr_data | input | 8 | Write data |
| addr_oe | output | 24 | Per-pin address output enable, bit n for line An |
| bus_wide | output | 1 | 1 for a 16-bit bus, 0 for an 8-bit bus |
| space_16m | output | 1 | 1 for a 16-Mbyte space, 0 for a 1-Mbyte space |

## Verification
A wrong latched mode appears on the first valid output cycle after reset, as a wrong `space_16m` or a wrong block of low or high enables. It stays there until the next reset, so pin changes made later must leave it as it is. A corrupted width, release or direction bit shows two edges after the write on `bus_wide` or on the matching `addr_oe` bit. The directed tests therefore sample one cycle after each write, to confirm the old value is still there, and again one cycle later. They also use walking and boundary patterns that tell each lane and each release bit apart.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    MODE1 = 3'd1,
    MODE2 = 3'd2,
    MODE3 = 3'd3,
    MODE4 = 3'd4,
    MODE5 = 3'd5,
    MODE6 = 3'd6
  } bus_mode_e;

  // Register selects on the write port
  localparam logic [2:0] SEL_AREA = 3'd0;
  localparam logic [2:0] SEL_REL  = 3'd1;
  localparam logic [2:0] SEL_DIR0 = 3'd2;

  typedef struct packed {
    logic wide24;     // 24 address lines
    logic start16;    // area register starts all 16-bit
    logic dir_gated;  // low pins wait for direction bits
  } mode_attr_t;

  function automatic bus_mode_e decode_mode(input logic [2:0] pins);
    case (pins)
      3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6: decode_mode = bus_mode_e'(pins);
      default:                            decode_mode = MODE1;
    endcase
  endfunction

  function automatic mode_attr_t attr_of(input bus_mode_e m);
    mode_attr_t a;
    a.wide24    = (m == MODE3) || (m == MODE4) || (m == MODE6);
    a.start16   = (m == MODE2) || (m == MODE4);
    a.dir_gated = (m == MODE5) || (m == MODE6);
    return a;
  endfunction

endpackage

// File: rtl/xbus_mode_latch.sv
module xbus_mode_latch
  import xbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode_pins,
  output logic       start16_now,
  output logic       wide24_q,
  output logic       dir_gated_q
);

  mode_attr_t attr_now;

  assign attr_now    = attr_of(decode_mode(mode_pins));
  assign start16_now = attr_now.start16;

  // Capture keeps updating while reset is held; the last edge wins
  always_ff @(posedge clk) begin
    if (rst) begin
      wide24_q    <= attr_now.wide24;
      dir_gated_q <= attr_now.dir_gated;
    end
  end

endmodule

// File: rtl/xbus_cfg_regs.sv
module xbus_cfg_regs
  import xbus_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AREA_N    = 8,
  parameter int LOW_W     = 20,
  parameter int HI_N      = 3,
  parameter logic [DW-1:0] REL_INIT = 8'hFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start16_now,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [AREA_N-1:0] area_q,
  output logic [HI_N-1:0]   rel_hi_q,
  output logic [LOW_W-1:0]  dir_q
);

  localparam int DIR_LANES = (LOW_W + DW - 1) / DW;
  localparam int REL_LO    = DW - HI_N;

  always_ff @(posedge clk) begin
    if (rst)
      area_q <= start16_now ? '1 : '0;
    else if (wr_en && wr_addr == SEL_AREA)
      area_q <= wr_data[AREA_N-1:0];
  end

  // Only the gating bits of the release register are stored
  always_ff @(posedge clk) begin
    if (rst)
      rel_hi_q <= REL_INIT[DW-1:REL_LO];
    else if (wr_en && wr_addr == SEL_REL)
      rel_hi_q <= wr_data[DW-1:REL_LO];
  end

  for (genvar g = 0; g < DIR_LANES; g++) begin : g_lane
    localparam int LW = ((LOW_W - DW*g) > DW) ? DW : (LOW_W - DW*g);
    logic [LW-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst)
        lane_q <= '0;
      else if (wr_en && wr_addr == 3'(SEL_DIR0 + 3'(g)))
        lane_q <= wr_data[LW-1:0];
    end
    assign dir_q[DW*g +: LW] = lane_q;
  end

endmodule

// File: rtl/xbus_pin_enable.sv
module xbus_pin_enable #(
  parameter int ADDR_W = 24,
  parameter int LOW_W  = 20,
  parameter int AREA_N = 8,
  parameter int HI_N   = 3
) (
  input  logic              wide24,
  input  logic              dir_gated,
  input  logic [AREA_N-1:0] area_q,
  input  logic [HI_N-1:0]   rel_hi_q,
  input  logic [LOW_W-1:0]  dir_q,
  output logic [ADDR_W-1:0] oe_next,
  output logic              wide_next
);

  for (genvar i = 0; i < ADDR_W; i++) begin : g_pin
    if (i < LOW_W) begin : g_low
      assign oe_next[i] = dir_gated ? dir_q[i] : 1'b1;
    end else if (i == LOW_W) begin : g_fixed
      assign oe_next[i] = wide24;
    end else begin : g_gated
      assign oe_next[i] = wide24 & ~rel_hi_q[i-LOW_W-1];
    end
  end

  assign wide_next = |area_q;

endmodule

// File: rtl/xbus_cfg.sv
module xbus_cfg
  import xbus_pkg::*;
#(
  parameter int DW     = 8,
  parameter int AREA_N = 8,
  parameter int ADDR_W = 24,
  parameter int LOW_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode_pins,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [ADDR_W-1:0] addr_oe,
  output logic              bus_wide,
  output logic              space_16m
);

  localparam int HI_N = ADDR_W - LOW_W - 1;

  logic              start16_now;
  logic              wide24_q;
  logic              dir_gated_q;
  logic [AREA_N-1:0] area_q;
  logic [HI_N-1:0]   rel_hi_q;
  logic [LOW_W-1:0]  dir_q;
  logic [ADDR_W-1:0] oe_next;
  logic              wide_next;

  xbus_mode_latch u_mode (
    .clk         (clk),
    .rst         (rst),
    .mode_pins   (mode_pins),
    .start16_now (start16_now),
    .wide24_q    (wide24_q),
    .dir_gated_q (dir_gated_q)
  );

  xbus_cfg_regs #(
    .DW(DW), .AREA_N(AREA_N), .LOW_W(LOW_W), .HI_N(HI_N)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .start16_now (start16_now),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .area_q      (area_q),
    .rel_hi_q    (rel_hi_q),
    .dir_q       (dir_q)
  );

  xbus_pin_enable #(
    .ADDR_W(ADDR_W), .LOW_W(LOW_W), .AREA_N(AREA_N), .HI_N(HI_N)
  ) u_pins (
    .wide24    (wide24_q),
    .dir_gated (dir_gated_q),
    .area_q    (area_q),
    .rel_hi_q  (rel_hi_q),
    .dir_q     (dir_q),
    .oe_next   (oe_next),
    .wide_next (wide_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_oe   <= '0;
      bus_wide  <= 1'b0;
      space_16m <= 1'b0;
    end else begin
      addr_oe   <= oe_next;
      bus_wide  <= wide_next;
      space_16m <= wide24_q;
    end
  end

endmodule

// File: rtl/xbus_cfg_chk.sv
module xbus_cfg_chk #(
  parameter int DW     = 8,
  parameter int AREA_N = 8,
  parameter int ADDR_W = 24,
  parameter int LOW_W  = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic [ADDR_W-1:0] addr_oe,
  input logic              bus_wide,
  input logic              space_16m,
  input logic              dir_gated
);

  AST_SMALL_SPACE_HIGH_OFF: assert property (@(posedge clk) disable iff (rst)
    !space_16m |-> addr_oe[ADDR_W-1:LOW_W] == '0); // R1

  AST_A20_ALWAYS_ON: assert property (@(posedge clk) disable iff (rst)
    space_16m |-> addr_oe[LOW_W]); // R6

  AST_WIDTH_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst, 2) && $past(!rst) && $past(wr_en && wr_addr == 3'd0, 2))
      |-> bus_wide == ($past(wr_data[AREA_N-1:0], 2) != '0)); // R4

  AST_LOW_PINS_UNGATED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !dir_gated) |-> &addr_oe[LOW_W-1:0]); // R8

  AST_SPACE_HELD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> $stable(space_16m)); // R9

endmodule

bind xbus_cfg xbus_cfg_chk #(
  .DW(DW), .AREA_N(AREA_N), .ADDR_W(ADDR_W), .LOW_W(LOW_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .addr_oe   (addr_oe),
  .bus_wide  (bus_wide),
  .space_16m (space_16m),
  .dir_gated (dir_gated_q)
);

// File: tb/xbus_cfg_test.sv
module xbus_cfg_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  mode_pins = 3'd1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [23:0] addr_oe;
  logic        bus_wide;
  logic        space_16m;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  xbus_cfg uut (
    .clk(clk), .rst(rst), .mode_pins(mode_pins),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .addr_oe(addr_oe), .bus_wide(bus_wide), .space_16m(space_16m)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_all(input string req, input logic [23:0] oe,
                            input logic wide, input logic sp);
    chk(req, {8'd0, addr_oe}, {8'd0, oe});
    chk(req, {31'd0, bus_wide}, {31'd0, wide});
    chk(req, {31'd0, space_16m}, {31'd0, sp});
  endtask

  // Reset with a mode code; returns at a negedge with outputs valid
  task automatic do_reset(input logic [2:0] m);
    @(negedge clk);
    mode_pins = m;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    expect_all("R10 outputs low in reset", 24'h0, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Write; returns at the negedge after the outputs have caught up
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_mode1;
    do_reset(3'd1);
    expect_all("R1 R2 R8 mode1 reset", 24'h0FFFFF, 1'b0, 1'b0);
    wr(3'd2, 8'h00);
    chk("R8 dir write ignored", {8'd0, addr_oe}, 32'h000FFFFF);
    // latency check on the area register
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 old width one cycle after write", {31'd0, bus_wide}, 32'd0);
    @(negedge clk);
    chk("R4 single area 16-bit", {31'd0, bus_wide}, 32'd1);
  endtask

  task automatic t_mode2;
    do_reset(3'd2);
    expect_all("R3 mode2 reset", 24'h0FFFFF, 1'b1, 1'b0);
    wr(3'd0, 8'h00);
    chk("R4 all areas 8-bit", {31'd0, bus_wide}, 32'd0);
  endtask

  task automatic t_mode3;
    do_reset(3'd3);
    expect_all("R5 R2 mode3 reset", 24'h1FFFFF, 1'b0, 1'b1);
    wr(3'd1, 8'h1F);
    chk("R5 release bits clear", {8'd0, addr_oe}, 32'h00FFFFFF);
    wr(3'd1, 8'h20);
    chk("R5 bit5 gates A21", {8'd0, addr_oe}, 32'h00DFFFFF);
    wr(3'd1, 8'h80);
    chk("R5 bit7 gates A23", {8'd0, addr_oe}, 32'h007FFFFF);
    wr(3'd1, 8'hE0);
    chk("R6 A20 stays on", {8'd0, addr_oe}, 32'h001FFFFF);
  endtask

  task automatic t_mode4;
    do_reset(3'd4);
    expect_all("R3 mode4 reset", 24'h1FFFFF, 1'b1, 1'b1);
    wr(3'd0, 8'h00);
    chk("R4 mode4 all 8-bit", {31'd0, bus_wide}, 32'd0);
    wr(3'd0, 8'h80);
    chk("R4 top area 16-bit", {31'd0, bus_wide}, 32'd1);
    wr(3'd3, 8'h00);
    chk("R8 mode4 dir write ignored", {8'd0, addr_oe}, 32'h001FFFFF);
  endtask

  task automatic t_mode5;
    do_reset(3'd5);
    expect_all("R7 mode5 reset", 24'h000000, 1'b0, 1'b0);
    wr(3'd2, 8'hA5);
    chk("R7 lane A7..A0", {8'd0, addr_oe}, 32'h000000A5);
    wr(3'd3, 8'h3C);
    chk("R7 lane A15..A8", {8'd0, addr_oe}, 32'h00003CA5);
    wr(3'd4, 8'hF9);
    chk("R7 lane A19..A16", {8'd0, addr_oe}, 32'h00093CA5);
    wr(3'd1, 8'h00);
    chk("R1 small space high lines off", {8'd0, addr_oe}, 32'h00093CA5);
  endtask

  task automatic t_mode6;
    do_reset(3'd6);
    expect_all("R7 R6 mode6 reset", 24'h100000, 1'b0, 1'b1);
    wr(3'd4, 8'h0F);
    chk("R7 mode6 upper lane", {8'd0, addr_oe}, 32'h001F0000);
    wr(3'd1, 8'h00);
    chk("R5 mode6 release clear", {8'd0, addr_oe}, 32'h00FF0000);
  endtask

  task automatic t_invalid;
    do_reset(3'd0);
    expect_all("R9 code 0 as mode1", 24'h0FFFFF, 1'b0, 1'b0);
    mode_pins = 3'd6;
    wr(3'd1, 8'h00);
    expect_all("R9 pins ignored after reset", 24'h0FFFFF, 1'b0, 1'b0);
    do_reset(3'd7);
    expect_all("R9 code 7 as mode1", 24'h0FFFFF, 1'b0, 1'b0);
  endtask

  initial begin
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode4();
    t_mode5();
    t_mode6();
    t_invalid();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule